// File: doc/BRIEF.md
# Fetch Cachability Attribute Selector

This block answers, for every instruction fetch address, whether the fetch may be placed in the instruction cache. The answer comes from one of two sources, and the translation-enable input picks between them. With translation on, the inhibit bit of the page entry that was already looked up decides; a 1 there forbids caching. Pages may be anywhere from 1 KB to 16 MB, and that lookup happens outside this block. With translation off, a 32-bit real-mode cachability register decides, and it uses the opposite sense: a 1 there allows caching. Each bit of that register covers one 128 MB slice of the address space.

Software reads and writes the real-mode register through a plain port with a write strobe. Caching also stays forbidden after reset until the cache array has been fully invalidated. A small two-state machine records the one-cycle invalidate-complete pulse. Its states are `ST_BLOCKED`, entered at reset, and `ST_OPEN`. The transition `ST_BLOCKED -> ST_OPEN` happens on an invalidate-complete pulse. `ST_BLOCKED -> ST_BLOCKED` happens when no pulse arrives. `ST_OPEN -> ST_OPEN` always holds, and only reset leaves `ST_OPEN`. The cachable output is the chosen attribute ANDed with being in `ST_OPEN`.

Top module: `fetch_cache_attr`

## Requirements
- R1: While reset is asserted and right after it is released, `region_rdata` reads 0 and `fetch_cachable` is 0 for any combination of the other inputs.
- R2: A write with `region_we`=1 is visible on `region_rdata` after the next rising clock edge; with `region_we`=0 the register keeps its value.
- R3: With `xlate_en`=0, the region index n is `fetch_addr[31:27]`, and the controlling bit is `region_rdata[31-n]` (bit 0 in big-endian numbering is the MSB, covering 0x0000_0000 to 0x07FF_FFFF). The fetch is cachable when that bit is 1.
- R4: With `xlate_en`=1, `fetch_cachable` equals the inverse of `page_inhibit`, whatever the register holds.
- R5: With `xlate_en`=0, `page_inhibit` has no effect on `fetch_cachable`.
- R6: Until an `inval_done` pulse has been seen since reset, `fetch_cachable` is 0 in both modes; it may become 1 from the clock edge that samples the pulse onward.
- R7: Once opened, caching stays enabled regardless of further `inval_done` activity until the next reset, which blocks it again.
- R8: `fetch_cachable` is combinational in `fetch_addr`, `xlate_en`, `page_inhibit` and the current register contents: it follows an address change with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Instruction translation enabled |
| page_inhibit | input | 1 | Inhibit attribute of the looked-up page entry |
| fetch_addr | input | 32 | Instruction fetch address |
| region_we | input | 1 | Write strobe for the real-mode register |
| region_wdata | input | 32 | Write data for the real-mode register |
| region_rdata | output | 32 | Current real-mode register contents |
| inval_done | input | 1 | One-cycle pulse: cache array invalidate completed |
| fetch_cachable | output | 1 | The current fetch may be cached |

## Verification
A wrong machine state shows at once at `fetch_cachable`. A machine stuck in `ST_BLOCKED` forces 0 on a fetch the selected attribute allows. One that opens early or spuriously shows a 1 before the first pulse. A lost or corrupted register bit shows as a wrong answer for exactly one 128 MB region in real mode, in the same cycle as the address. Such a fault also shows one edge after a write through `region_rdata`. This is why each region is probed at its first and last address with one-hot and one-cold patterns.

// File: rtl/fca_pkg.sv
package fca_pkg;
    localparam int FCA_ADDR_W      = 32;
    localparam int FCA_REGION_BITS = 5;

    typedef enum logic {
        ST_BLOCKED = 1'b0,
        ST_OPEN    = 1'b1
    } inval_state_e;
endpackage

// File: rtl/fca_region_reg.sv
module fca_region_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

    // R2: a write lands on the following edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(wdata)));
    // R2: no strobe, no change
    p_hold_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/fca_inval_fsm.sv
module fca_inval_fsm
    import fca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inval_done,
    output logic cache_open
);
    inval_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BLOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLOCKED: if (inval_done) state_d = ST_OPEN;
            ST_OPEN:    state_d = ST_OPEN;
            default:    state_d = ST_BLOCKED;
        endcase
    end

    always_comb begin
        cache_open = 1'b0;
        unique case (state_q)
            ST_BLOCKED: cache_open = 1'b0;
            ST_OPEN:    cache_open = 1'b1;
            default:    cache_open = 1'b0;
        endcase
    end

    // R6: the pulse opens the machine on the sampling edge
    p_open_on_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCKED && inval_done) |=> (state_q == ST_OPEN));
    // R6: without a pulse the machine stays blocked
    p_stay_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCKED && !inval_done) |=> (state_q == ST_BLOCKED));
    // R7: open is sticky
    p_sticky_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN) |=> (state_q == ST_OPEN));
endmodule

// File: rtl/fca_attr_mux.sv
module fca_attr_mux #(
    parameter int REGION_BITS = 5,
    localparam int NUM_REGIONS = 1 << REGION_BITS
) (
    input  logic                   xlate_en,
    input  logic                   page_inhibit,
    input  logic [REGION_BITS-1:0] region_idx,
    input  logic [NUM_REGIONS-1:0] region_bits,
    output logic                   attr_ok
);
    // Big-endian bit order: index 0 is the register MSB.
    logic [NUM_REGIONS-1:0] by_index;

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_reverse
        assign by_index[i] = region_bits[NUM_REGIONS-1-i];
    end

    logic real_ok;
    assign real_ok = by_index[region_idx];

    always_comb begin
        if (xlate_en) begin
            attr_ok = ~page_inhibit;
        end else begin
            attr_ok = real_ok;
        end
    end
endmodule

// File: rtl/fetch_cache_attr.sv
module fetch_cache_attr
    import fca_pkg::*;
#(
    parameter int ADDR_W      = FCA_ADDR_W,
    parameter int REGION_BITS = FCA_REGION_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        xlate_en,
    input  logic                        page_inhibit,
    input  logic [ADDR_W-1:0]           fetch_addr,
    input  logic                        region_we,
    input  logic [(1<<REGION_BITS)-1:0] region_wdata,
    output logic [(1<<REGION_BITS)-1:0] region_rdata,
    input  logic                        inval_done,
    output logic                        fetch_cachable
);
    localparam int NUM_REGIONS = 1 << REGION_BITS;
    localparam int LOW_W       = ADDR_W - REGION_BITS;

    logic [REGION_BITS-1:0] region_idx;
    logic [LOW_W-1:0]       unused_low_addr;
    logic                   cache_open;
    logic                   attr_ok;

    assign region_idx      = fetch_addr[ADDR_W-1 -: REGION_BITS];
    assign unused_low_addr = fetch_addr[LOW_W-1:0];

    fca_region_reg #(.WIDTH(NUM_REGIONS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (region_we),
        .wdata (region_wdata),
        .q     (region_rdata)
    );

    fca_inval_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .inval_done (inval_done),
        .cache_open (cache_open)
    );

    fca_attr_mux #(.REGION_BITS(REGION_BITS)) u_mux (
        .xlate_en     (xlate_en),
        .page_inhibit (page_inhibit),
        .region_idx   (region_idx),
        .region_bits  (region_rdata),
        .attr_ok      (attr_ok)
    );

    assign fetch_cachable = attr_ok & cache_open;

    // R6: nothing is cachable before invalidation completes
    p_blocked_no_cache_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_open |-> !fetch_cachable);
    // R4: an inhibited page is never cachable in translated mode
    p_inhibit_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xlate_en && page_inhibit) |-> !fetch_cachable);
    // R3: a clear register never yields a real-mode cachable fetch
    p_empty_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlate_en && region_rdata == '0) |-> !fetch_cachable);
endmodule

// File: tb/tb_fetch_cache_attr.sv
`timescale 1ns/1ps
module tb_fetch_cache_attr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0;
    logic        page_inhibit = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        region_we = 1'b0;
    logic [31:0] region_wdata = '0;
    logic [31:0] region_rdata;
    logic        inval_done = 1'b0;
    logic        fetch_cachable;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] model = '0;

    always #5 clk = ~clk;

    fetch_cache_attr dut (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .page_inhibit(page_inhibit),
        .fetch_addr(fetch_addr), .region_we(region_we), .region_wdata(region_wdata),
        .region_rdata(region_rdata), .inval_done(inval_done),
        .fetch_cachable(fetch_cachable)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] v);
        @(negedge clk);
        region_we = 1'b1;
        region_wdata = v;
        @(negedge clk);
        region_we = 1'b0;
        model = v;
    endtask

    function automatic logic real_exp(input logic [31:0] a);
        return model[31 - a[31:27]];
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        xlate_en = 1'b1;
        page_inhibit = 1'b0;
        #1;
        check("R1 rdata in reset", region_rdata, 32'h0);
        check("R1 cachable in reset", {31'b0, fetch_cachable}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        @(negedge clk);
        check("R1 rdata after reset", region_rdata, 32'h0);
        xlate_en = 1'b0;
        #1;
        check("R1 cachable after reset", {31'b0, fetch_cachable}, 32'h0);
    endtask

    task automatic t_blocked();
        do_write(32'hFFFF_FFFF);
        xlate_en = 1'b0;
        fetch_addr = 32'h1234_5678;
        #1;
        check("R6 real mode blocked", {31'b0, fetch_cachable}, 32'h0);
        xlate_en = 1'b1;
        page_inhibit = 1'b0;
        #1;
        check("R6 translated blocked", {31'b0, fetch_cachable}, 32'h0);
        @(negedge clk);
        inval_done = 1'b1;
        #1;
        check("R6 same cycle still blocked", {31'b0, fetch_cachable}, 32'h0);
        @(negedge clk);
        inval_done = 1'b0;
        #1;
        check("R6 open after pulse", {31'b0, fetch_cachable}, 32'h1);
    endtask

    task automatic t_write_read();
        do_write(32'hA5C3_0F96);
        check("R2 write visible", region_rdata, 32'hA5C3_0F96);
        @(negedge clk);
        region_wdata = 32'h0000_FFFF;
        @(negedge clk);
        check("R2 no strobe keeps value", region_rdata, 32'hA5C3_0F96);
    endtask

    task automatic t_regions();
        xlate_en = 1'b0;
        for (int pat = 0; pat < 2; pat++) begin
            for (int n = 0; n < 32; n++) begin
                logic [31:0] v;
                logic [31:0] base;
                logic [31:0] last;
                v = 32'h8000_0000 >> n;
                if (pat == 1) v = ~v;
                do_write(v);
                base = 32'(n) << 27;
                last = base | 32'h07FF_FFFF;
                fetch_addr = base;
                #1;
                check("R3 region first addr", {31'b0, fetch_cachable}, {31'b0, real_exp(base)});
                fetch_addr = last;
                #1;
                check("R8 region last addr", {31'b0, fetch_cachable}, {31'b0, real_exp(last)});
                if (n > 0) begin
                    fetch_addr = base - 1;
                    #1;
                    check("R3 below region", {31'b0, fetch_cachable}, {31'b0, real_exp(base - 1)});
                end
                if (n < 31) begin
                    fetch_addr = last + 1;
                    #1;
                    check("R3 above region", {31'b0, fetch_cachable}, {31'b0, real_exp(last + 1)});
                end
            end
        end
    endtask

    task automatic t_xlate();
        do_write(32'h0000_0000);
        xlate_en = 1'b1;
        fetch_addr = 32'h4000_0000;
        page_inhibit = 1'b0;
        #1;
        check("R4 clear inhibit cachable", {31'b0, fetch_cachable}, 32'h1);
        page_inhibit = 1'b1;
        #1;
        check("R4 set inhibit blocks", {31'b0, fetch_cachable}, 32'h0);
        do_write(32'hFFFF_FFFF);
        #1;
        check("R4 register ignored", {31'b0, fetch_cachable}, 32'h0);
        xlate_en = 1'b0;
        do_write(32'h0000_0001);
        fetch_addr = 32'hF800_0000;
        page_inhibit = 1'b1;
        #1;
        check("R5 inhibit ignored set", {31'b0, fetch_cachable}, 32'h1);
        page_inhibit = 1'b0;
        fetch_addr = 32'h0000_0000;
        #1;
        check("R5 inhibit ignored clear", {31'b0, fetch_cachable}, 32'h0);
    endtask

    task automatic t_sticky();
        xlate_en = 1'b1;
        page_inhibit = 1'b0;
        @(negedge clk);
        inval_done = 1'b1;
        @(negedge clk);
        inval_done = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 stays open", {31'b0, fetch_cachable}, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        #1;
        check("R7 reset blocks again", {31'b0, fetch_cachable}, 32'h0);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_blocked();
        t_write_read();
        t_regions();
        t_xlate();
        t_sticky();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule